// File: doc/BRIEF.md
# Associative Weight Memory with Masked Search

This block stores the weights of a cerebellar-model style learning controller. It replaces hashed addressing with an associative lookup. Each slot holds a tag and a signed weight at the same index. The tag is a conceptual address and sits in a content-addressable array; the weight sits in a separate RAM. A request presents a conceptual address, and all valid tags are compared against it in one cycle.

When no tag equals the address, the search widens one step per cycle. Each step ignores one more low-order address bit, up to `MAX_MASK` bits. The first step that finds a tag ends the search, and that entry's weight is shared between the two addresses. If even the widest step finds nothing, the address takes the slot named by a sequential fill pointer, with a fixed initial weight. A recall returns the weight. A train request also applies a scaled and saturated error correction to the selected weight, and the response carries the corrected value.

Requests use a valid/ready handshake. One request is in flight at a time. Each request produces a single-cycle response.

Top module: `awm_assoc_mem`

## Requirements
- R1: After reset, req_ready is high, rsp_valid is low and every slot is empty, so the first request allocates slot 0. An empty slot never matches at any mask level.
- R2: A request whose address equals a stored tag returns that slot's weight, its index and mask level 0, with rsp_alloc and rsp_full low. A recall leaves the weight unchanged.
- R3: At mask level L, a slot matches when its tag and the address agree in every bit above the L lowest bits. L runs from 0 to MAX_MASK (default 3), one level per cycle. The first level with a match ends the search, and rsp_mask reports that level. When several slots match, the lowest index wins.
- R4: When no level matches and a slot is free, the address is written to the slot at the fill pointer with weight INIT_WT (default 16). The response has rsp_alloc high, rsp_mask equal to MAX_MASK and rsp_index equal to that slot. The pointer then advances by one, so slots fill 0, 1, 2 and so on.
- R5: When no level matches and all DEPTH (default 8) slots are taken, nothing is written. The response has weight 0, index 0, rsp_mask equal to MAX_MASK, rsp_full high and rsp_alloc low, and a train request changes no weight.
- R6: A train request replaces the selected weight w with w + ((err * rate) >>> SHIFT), saturated to the signed WT_W range. err is a signed ERR_W value, rate is an unsigned RATE_W value, and the defaults are SHIFT 2 and WT_W 12. The response and all later lookups carry the new value.
- R7: A request is accepted on a clock edge with req_valid and req_ready both high. req_ready then stays low until the response completes. rsp_valid is high for exactly one cycle, L+1 edges after the accepting edge, where L is the reported mask level. A train request that is not answered as full takes L+2 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_train | input | 1 | 1 = train (read-modify-write), 0 = recall |
| req_addr | input | ADDR_W | Conceptual address |
| req_err | input | ERR_W | Signed training error |
| req_rate | input | RATE_W | Unsigned learning rate |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_weight | output | WT_W | Returned (or updated) signed weight |
| rsp_index | output | IDX_W | Slot used |
| rsp_mask | output | LVL_W | Number of low bits ignored at the hit |
| rsp_alloc | output | 1 | A slot was allocated |
| rsp_full | output | 1 | Total miss with no free slot |

## Verification
A wrong tag or valid bit shows up on the next request that touches that neighbourhood. It appears either as a mask level or index that differs from the reference, or as an allocation that should not happen. A fault in the fill pointer shows up as a wrong rsp_index on the next allocation, or as rsp_full arriving early or late. A fault in the update arithmetic shows up in the train response itself. It also shows up on every later recall of that slot, including after many training steps that drive the weight into saturation at both ends.

// File: rtl/awm_pkg.sv
package awm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_UPDATE = 2'd2,
    ST_RESP   = 2'd3
  } awm_state_e;
endpackage

// File: rtl/awm_cam.sv
// Tag array with per-slot valid bits and a parallel masked compare.
module awm_cam #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8,
  parameter int LVL_W  = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic [LVL_W-1:0]  cmp_lvl,
  output logic [DEPTH-1:0]  match
);
  logic [ADDR_W-1:0] tag_q [DEPTH];
  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [ADDR_W-1:0] keep;

  // bits at and above cmp_lvl take part in the compare
  assign keep = {ADDR_W{1'b1}} << cmp_lvl;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(i))) begin
        tag_q[i] <= wr_addr;
      end
    end
    assign match[i] = vld_q[i] && (((tag_q[i] ^ cmp_addr) & keep) == '0);
  end

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= vld_d;
  end

  AST_ALLOC_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |-> !vld_q[wr_idx]); // R4
endmodule

// File: rtl/awm_prio.sv
// Lowest-index-first priority encoder over the match vector.
module awm_prio #(
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] match,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = |match;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/awm_wram.sv
// Weight RAM, one asynchronous read port and one write port.
module awm_wram #(
  parameter int WT_W   = 12,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic signed [WT_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic signed [WT_W-1:0]  rd_data
);
  logic signed [WT_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/awm_train_alu.sv
// w + ((err * rate) >>> SHIFT), saturated to WT_W bits.
module awm_train_alu #(
  parameter int WT_W   = 12,
  parameter int ERR_W  = 8,
  parameter int RATE_W = 4,
  parameter int SHIFT  = 2
) (
  input  logic signed [WT_W-1:0]  wt_in,
  input  logic signed [ERR_W-1:0] err,
  input  logic [RATE_W-1:0]       rate,
  output logic signed [WT_W-1:0]  wt_out
);
  localparam int PW = ERR_W + RATE_W + 1;
  localparam int SW = PW + WT_W;

  logic signed [PW-1:0] err_x, rate_x, prod, delta;
  logic signed [SW-1:0] sum;
  logic                 ovf;

  assign err_x  = {{(PW-ERR_W){err[ERR_W-1]}}, err};
  assign rate_x = {{(PW-RATE_W){1'b0}}, rate};
  assign prod   = err_x * rate_x;
  assign delta  = prod >>> SHIFT;
  assign sum    = {{(SW-WT_W){wt_in[WT_W-1]}}, wt_in} + {{(SW-PW){delta[PW-1]}}, delta};
  assign ovf    = (sum[SW-1:WT_W-1] != {(SW-WT_W+1){sum[SW-1]}});

  always_comb begin
    if (!ovf)              wt_out = sum[WT_W-1:0];
    else if (sum[SW-1])    wt_out = {1'b1, {(WT_W-1){1'b0}}};
    else                   wt_out = {1'b0, {(WT_W-1){1'b1}}};
  end
endmodule

// File: rtl/awm_assoc_mem.sv
module awm_assoc_mem
  import awm_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DEPTH    = 8,
  parameter int MAX_MASK = 3,
  parameter int WT_W     = 12,
  parameter int ERR_W    = 8,
  parameter int RATE_W   = 4,
  parameter int SHIFT    = 2,
  parameter int INIT_WT  = 16,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int LVL_W   = $clog2(MAX_MASK + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_train,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic signed [ERR_W-1:0] req_err,
  input  logic [RATE_W-1:0]      req_rate,
  output logic                   rsp_valid,
  output logic signed [WT_W-1:0] rsp_weight,
  output logic [IDX_W-1:0]       rsp_index,
  output logic [LVL_W-1:0]       rsp_mask,
  output logic                   rsp_alloc,
  output logic                   rsp_full
);
  localparam int PTR_W = $clog2(DEPTH + 1);

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  awm_state_e              state_q, state_d;
  logic [LVL_W-1:0]        lvl_q, lvl_d;
  logic [PTR_W-1:0]        ptr_q, ptr_d;
  logic [IDX_W-1:0]        sel_q, sel_d;
  logic [ADDR_W-1:0]       addr_q;
  logic                    train_q;
  logic signed [ERR_W-1:0] err_q;
  logic [RATE_W-1:0]       rate_q;
  logic signed [WT_W-1:0]  rw_q, rw_d;
  logic [IDX_W-1:0]        ridx_q, ridx_d;
  logic [LVL_W-1:0]        rmask_q, rmask_d;
  logic                    ralloc_q, ralloc_d, rfull_q, rfull_d;
  logic                    ld_req;

  logic [DEPTH-1:0]        match;
  logic                    pe_hit;
  logic [IDX_W-1:0]        pe_idx;
  logic                    cam_wr, ram_wr;
  logic [IDX_W-1:0]        ram_widx, ram_ridx;
  logic signed [WT_W-1:0]  ram_wdata, ram_rdata, alu_out;
  logic                    is_full;

  assign is_full = (ptr_q == PTR_W'(DEPTH));

  awm_cam #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_cam (
    .clk(clk), .rst_ni(rst_ni), .wr_en(cam_wr), .wr_idx(ptr_q[IDX_W-1:0]),
    .wr_addr(addr_q), .cmp_addr(addr_q), .cmp_lvl(lvl_q), .match(match)
  );

  awm_prio #(.DEPTH(DEPTH)) u_prio (.match(match), .hit(pe_hit), .idx(pe_idx));

  awm_wram #(.WT_W(WT_W), .DEPTH(DEPTH)) u_wram (
    .clk(clk), .wr_en(ram_wr), .wr_idx(ram_widx), .wr_data(ram_wdata),
    .rd_idx(ram_ridx), .rd_data(ram_rdata)
  );

  awm_train_alu #(.WT_W(WT_W), .ERR_W(ERR_W), .RATE_W(RATE_W), .SHIFT(SHIFT)) u_alu (
    .wt_in(ram_rdata), .err(err_q), .rate(rate_q), .wt_out(alu_out)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    lvl_d     = lvl_q;
    ptr_d     = ptr_q;
    sel_d     = sel_q;
    rw_d      = rw_q;
    ridx_d    = ridx_q;
    rmask_d   = rmask_q;
    ralloc_d  = ralloc_q;
    rfull_d   = rfull_q;
    ld_req    = 1'b0;
    cam_wr    = 1'b0;
    ram_wr    = 1'b0;
    ram_widx  = sel_q;
    ram_wdata = alu_out;
    ram_ridx  = (state_q == ST_SEARCH) ? pe_idx : sel_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req  = 1'b1;
          lvl_d   = '0;
          state_d = ST_SEARCH;
        end
      end
      ST_SEARCH: begin
        if (pe_hit) begin
          sel_d    = pe_idx;
          rw_d     = ram_rdata;
          ridx_d   = pe_idx;
          rmask_d  = lvl_q;
          ralloc_d = 1'b0;
          rfull_d  = 1'b0;
          state_d  = train_q ? ST_UPDATE : ST_RESP;
        end else if (lvl_q != LVL_W'(MAX_MASK)) begin
          lvl_d = lvl_q + 1'b1;
        end else if (!is_full) begin
          cam_wr    = 1'b1;
          ram_wr    = 1'b1;
          ram_widx  = ptr_q[IDX_W-1:0];
          ram_wdata = WT_W'(INIT_WT);
          sel_d     = ptr_q[IDX_W-1:0];
          ptr_d     = ptr_q + 1'b1;
          rw_d      = WT_W'(INIT_WT);
          ridx_d    = ptr_q[IDX_W-1:0];
          rmask_d   = lvl_q;
          ralloc_d  = 1'b1;
          rfull_d   = 1'b0;
          state_d   = train_q ? ST_UPDATE : ST_RESP;
        end else begin
          rw_d     = '0;
          ridx_d   = '0;
          rmask_d  = lvl_q;
          ralloc_d = 1'b0;
          rfull_d  = 1'b1;
          state_d  = ST_RESP;
        end
      end
      ST_UPDATE: begin
        ram_wr    = 1'b1;
        ram_widx  = sel_q;
        ram_wdata = alu_out;
        rw_d      = alu_out;
        state_d   = ST_RESP;
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      lvl_q    <= '0;
      ptr_q    <= '0;
      sel_q    <= '0;
      rw_q     <= '0;
      ridx_q   <= '0;
      rmask_q  <= '0;
      ralloc_q <= 1'b0;
      rfull_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      lvl_q    <= lvl_d;
      ptr_q    <= ptr_d;
      sel_q    <= sel_d;
      rw_q     <= rw_d;
      ridx_q   <= ridx_d;
      rmask_q  <= rmask_d;
      ralloc_q <= ralloc_d;
      rfull_q  <= rfull_d;
    end
  end

  // request capture, enable only
  always_ff @(posedge clk) begin
    if (ld_req) begin
      addr_q  <= req_addr;
      train_q <= req_train;
      err_q   <= req_err;
      rate_q  <= req_rate;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = (state_q == ST_RESP);
  assign rsp_weight = rw_q;
  assign rsp_index  = ridx_q;
  assign rsp_mask   = rmask_q;
  assign rsp_alloc  = ralloc_q;
  assign rsp_full   = rfull_q;

  AST_PTR_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(ptr_q) |-> (ptr_q == $past(ptr_q) + 1'b1)); // R4
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_ready) |=> !req_ready); // R7
  AST_RSP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid |=> !rsp_valid); // R7
  AST_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_valid && rsp_full) |-> (!rsp_alloc && rsp_weight == '0)); // R5
  AST_MASK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid |-> (rsp_mask <= LVL_W'(MAX_MASK))); // R3
endmodule

// File: tb/tb_awm_assoc_mem.sv
`timescale 1ns/1ps
module tb_awm_assoc_mem;
  localparam int ADDR_W = 8, DEPTH = 8, MAX_MASK = 3, WT_W = 12;
  localparam int ERR_W = 8, RATE_W = 4, SHIFT = 2, INIT_WT = 16;
  localparam int WMAX = 2047, WMIN = -2048;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_train;
  logic [ADDR_W-1:0] req_addr;
  logic signed [ERR_W-1:0] req_err;
  logic [RATE_W-1:0] req_rate;
  logic req_ready, rsp_valid, rsp_alloc, rsp_full;
  logic signed [WT_W-1:0] rsp_weight;
  logic [2:0] rsp_index;
  logic [1:0] rsp_mask;

  always #2.5 clk = ~clk;

  awm_assoc_mem dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_train(req_train), .req_addr(req_addr), .req_err(req_err), .req_rate(req_rate),
    .rsp_valid(rsp_valid), .rsp_weight(rsp_weight), .rsp_index(rsp_index),
    .rsp_mask(rsp_mask), .rsp_alloc(rsp_alloc), .rsp_full(rsp_full)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  int m_tag [DEPTH];
  int m_wt  [DEPTH];
  bit m_vld [DEPTH];
  int m_ptr;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v > WMAX) return WMAX;
    if (v < WMIN) return WMIN;
    return v;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
    m_ptr = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
  endtask

  task automatic do_req(input bit tr, input int a, input int err, input int rate);
    int e_idx, e_lvl, e_wt, e_lat, n;
    bit e_alloc, e_full, found;
    string rq;
    found = 0; e_idx = 0; e_lvl = MAX_MASK; e_alloc = 0; e_full = 0; e_wt = 0;
    for (int l = 0; l <= MAX_MASK && !found; l++)
      for (int i = 0; i < DEPTH && !found; i++)
        if (m_vld[i] && (((m_tag[i] ^ a) >> l) == 0)) begin
          found = 1; e_idx = i; e_lvl = l; e_wt = m_wt[i];
        end
    e_lat = e_lvl + 1;
    if (found) rq = (e_lvl == 0) ? "R2" : "R3";
    else if (m_ptr < DEPTH) begin
      rq = "R4"; e_idx = m_ptr; e_alloc = 1; e_wt = INIT_WT;
      m_tag[m_ptr] = a; m_vld[m_ptr] = 1; m_wt[m_ptr] = INIT_WT; m_ptr++;
    end else begin
      rq = "R5"; e_full = 1;
    end
    if (tr && !e_full) begin
      e_wt = sat(e_wt + ((err * rate) >>> SHIFT));
      m_wt[e_idx] = e_wt; e_lat++; rq = "R6";
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_train = tr; req_addr = a[ADDR_W-1:0];
    req_err = err[ERR_W-1:0]; req_rate = rate[RATE_W-1:0];
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 40) begin @(negedge clk); n++; end
    chk(n == e_lat, "R7", "latency", n, e_lat);
    chk(int'(rsp_weight) == e_wt, rq, "weight", rsp_weight, e_wt);
    chk(int'(rsp_index) == e_idx, rq, "index", rsp_index, e_idx);
    chk(int'(rsp_mask) == e_lvl, rq, "mask", rsp_mask, e_lvl);
    chk(rsp_alloc == e_alloc, rq, "alloc", rsp_alloc, e_alloc);
    chk(rsp_full == e_full, rq, "full", rsp_full, e_full);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7", "single-cycle response", rsp_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    rst_n = 1'b0; req_valid = 1'b0; req_train = 1'b0;
    req_addr = '0; req_err = '0; req_rate = '0;
    seed = $urandom(32'd4242);

    // R1: first request after reset lands in slot 0
    do_reset();
    for (int k = 0; k < DEPTH; k++) do_req(0, k * 16, 0, 0);     // R4 sequential fill
    do_req(0, 8'h10, 0, 0);                                      // R2 exact
    do_req(0, 8'h01, 0, 0);                                      // R3 level 1
    do_req(0, 8'h03, 0, 0);                                      // R3 level 2
    do_req(0, 8'h05, 0, 0);                                      // R3 level 3
    do_req(0, 8'h17, 0, 0);                                      // R3 level 3 slot 1
    do_req(0, 8'h88, 0, 0);                                      // R5 full
    do_req(1, 8'h88, 100, 15);                                   // R5 full train, no write
    do_req(0, 8'h70, 0, 0);                                      // R5 earlier slot intact
    for (int k = 0; k < 6; k++) do_req(1, 8'h20, 127, 15);       // R6 saturate high
    do_req(1, 8'h21, 50, 0);                                     // R6 zero rate
    for (int k = 0; k < 10; k++) do_req(1, 8'h22, -128, 15);     // R6 saturate low
    do_req(0, 8'h20, 0, 0);                                      // R6 stored value

    // R1: reset mid-run empties all slots
    do_reset();
    do_req(0, 8'h70, 0, 0);

    for (int r = 0; r < 3; r++) begin
      do_reset();
      for (int k = 0; k < 50; k++)
        do_req($urandom_range(0, 1), $urandom_range(0, 95),
               $signed($urandom_range(0, 255)) - 128, $urandom_range(0, 15));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule